// File: doc/BRIEF.md
# Iterative Greatest Common Divisor Engine

This block computes the greatest common divisor of two unsigned operands, one request at a time. It does no division. Each working cycle it either exchanges the two operand registers, when the first is smaller than the second, or it replaces the first register with the difference of the two. It finishes once the first register is at least the second and the second has reached zero. The first register then holds the answer.

Requests enter on a valid/ready handshake and answers leave on a second valid/ready handshake. The input side is ready only while the engine is idle. An answer is presented until the consumer takes it, and only then does the engine become idle again. The operand width is a parameter.

Top module: `gcd_iter`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid` is 0 (the idle state, state code 0).
- R2: While idle, `req_ready` is 1 and both operand registers load from `opa` and `opb`. A clock edge with `req_valid` high accepts the pair and moves the engine to the computing state (code 1), where `req_ready` is 0.
- R3: While computing, if the first register is less than the second, both registers are written in the same cycle, each taking the other's old value.
- R4: While computing, if the first register is not less than the second and the second is nonzero, only the first register is written, with first minus second. The second register holds.
- R5: While computing, the engine moves to the answer state (code 2) once the first register is not less than the second and the second is zero. The number of computing cycles, counting that final cycle, equals the number of exchange and subtract steps plus one.
- R6: In the answer state `rsp_valid` is 1 and `result` is stable. The engine stays there while `rsp_ready` is 0, and returns to idle on the first clock edge with `rsp_ready` high.
- R7: Zero operands follow the same rules: gcd(x,0)=x, gcd(0,x)=x and gcd(0,0)=0.
- R8: `req_ready` and `rsp_valid` are never high together. Changes on `opa`, `opb` and `req_valid` while the engine is not idle have no effect on the answer.
- R9: The value on `result` while `rsp_valid` is high is the greatest common divisor of the accepted pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Operand pair offered |
| req_ready | output | 1 | Engine idle and accepting operands |
| opa | input | W | First operand |
| opb | input | W | Second operand |
| rsp_valid | output | 1 | Answer present |
| rsp_ready | input | 1 | Consumer takes the answer |
| result | output | W | Answer, taken from the first register |

## Verification
The assertions assume that the clock runs and that reset is released synchronously to it. They make no assumption about how the handshake inputs behave, so the bench may wiggle `req_valid`, `opa` and `opb` freely while the engine is busy. The stimulus keeps every computation short: random operands are limited to 8 bits and only one directed pair is large, so the subtract chain never needs more cycles than the bench allows. The bench drives all inputs at the falling edge, which keeps each one steady across the rising edge that samples it.

// File: rtl/gcd_iter.sv
module gcd_iter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  output logic         req_ready,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic         rsp_valid,
  input  logic         rsp_ready,
  output logic [W-1:0] result
);

  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_RUN = 2'd1, ST_HOLD = 2'd2} st_t;

  localparam logic [1:0] ASEL_IN   = 2'd0;
  localparam logic [1:0] ASEL_B    = 2'd1;
  localparam logic [1:0] ASEL_DIFF = 2'd2;
  localparam logic       BSEL_IN   = 1'b0;
  localparam logic       BSEL_A    = 1'b1;

  st_t         st, st_nx;
  logic [W-1:0] a_q, b_q, a_d, b_d, diff;
  logic [1:0]  a_sel;
  logic        b_sel, a_en, b_en, a_lt_b, b_zero;

  assign diff   = a_q - b_q;
  assign a_lt_b = a_q < b_q;
  assign b_zero = b_q == '0;
  assign result = a_q;

  always_comb begin
    a_en = 1'b0; b_en = 1'b0; a_sel = 'x; b_sel = 'x;
    req_ready = 1'b0; rsp_valid = 1'b0;
    st_nx = st;
    case (st)
      ST_IDLE: begin
        a_sel = ASEL_IN; b_sel = BSEL_IN; a_en = 1'b1; b_en = 1'b1;
        req_ready = 1'b1;
        if (req_valid) st_nx = ST_RUN;
      end
      ST_RUN: begin
        if (a_lt_b) begin
          a_sel = ASEL_B; b_sel = BSEL_A; a_en = 1'b1; b_en = 1'b1;
        end else if (!b_zero) begin
          a_sel = ASEL_DIFF; a_en = 1'b1;
        end else begin
          st_nx = ST_HOLD;
        end
      end
      ST_HOLD: begin
        rsp_valid = 1'b1;
        if (rsp_ready) st_nx = ST_IDLE;
      end
      default: st_nx = ST_IDLE;
    endcase
  end

  always_comb begin
    case (a_sel)
      ASEL_IN:   a_d = opa;
      ASEL_B:    a_d = b_q;
      ASEL_DIFF: a_d = diff;
      default:   a_d = 'x;
    endcase
    b_d = (b_sel == BSEL_A) ? a_q : opb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      a_q <= '0;
      b_q <= '0;
    end else begin
      st <= st_nx;
      if (a_en) a_q <= a_d;
      if (b_en) b_q <= b_d;
    end
  end

  // R8
  excl_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && rsp_valid));

  // R2
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!req_ready && a_q == $past(opa) && b_q == $past(opb)));

  // R3
  swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN && a_q < b_q) |=> (a_q == $past(b_q) && b_q == $past(a_q)));

  // R4
  sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN && a_q >= b_q && b_q != '0) |=>
      (a_q == W'($past(a_q) - $past(b_q)) && $stable(b_q)));

  // R5
  done_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (b_q == '0));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(result)));

  // R6
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready) |=> (req_ready && !rsp_valid));

endmodule

// File: tb/gcd_iter_test.sv
`timescale 1ns/1ps
module gcd_iter_test;
  localparam int W = 16;
  localparam int LIMIT = 5000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, rsp_ready = 1'b0;
  logic [W-1:0] opa = '0, opb = '0;
  logic req_ready, rsp_valid;
  logic [W-1:0] result;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  gcd_iter #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .opa(opa), .opb(opb), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .result(result)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int euclid(input int x, input int y);
    int p = x, q = y;
    while (q != 0) begin
      int t = p % q;
      p = q;
      q = t;
    end
    return p;
  endfunction

  function automatic int steps(input int x, input int y);
    int p = x, q = y, n = 0;
    forever begin
      n++;
      if (p < q) begin int t = p; p = q; q = t; end
      else if (q != 0) p = p - q;
      else break;
    end
    return n;
  endfunction

  task automatic run_pair(input int x, input int y, input int gap, input int stall, input bit noise);
    int cnt;
    for (int i = 0; i < gap; i++) begin
      @(negedge clk);
      check("R2 idle ready during gap", req_ready, 1);
    end
    @(negedge clk);
    opa = W'(x); opb = W'(y); req_valid = 1'b1;
    check("R2 ready before accept", req_ready, 1);
    @(negedge clk);
    req_valid = noise;
    if (noise) begin opa = W'($urandom); opb = W'($urandom); end
    check("R2 busy after accept", req_ready, 0);
    cnt = 0;
    while (!rsp_valid && cnt < LIMIT) begin
      @(negedge clk);
      if (noise) begin opa = W'($urandom); opb = W'($urandom); end
      cnt++;
    end
    req_valid = 1'b0;
    check("R5 compute cycles (R3 swap, R4 subtract)", cnt, steps(x, y));
    check("R9 result", result, euclid(x, y));
    check("R8 no ready while answer", req_ready, 0);
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      check("R6 valid held", rsp_valid, 1);
      check("R6 result stable", result, euclid(x, y));
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    check("R6 released valid", rsp_valid, 0);
    check("R6 back to idle", req_ready, 1);
  endtask

  task automatic t_reset();
    check("R1 reset ready", req_ready, 1);
    check("R1 reset no answer", rsp_valid, 0);
  endtask

  task automatic t_directed();
    run_pair(3, 6, 0, 0, 0);
    run_pair(6, 3, 2, 1, 0);
    run_pair(48, 18, 0, 3, 0);
    run_pair(17, 5, 1, 0, 0);
    run_pair(1000, 1, 0, 0, 0);
  endtask

  task automatic t_zero();
    run_pair(9, 0, 0, 0, 0);   // R7
    run_pair(0, 9, 0, 1, 0);   // R7
    run_pair(0, 0, 0, 0, 0);   // R7
  endtask

  task automatic t_noise();
    run_pair(84, 36, 0, 2, 1); // R8 inputs ignored while busy
    run_pair(35, 64, 0, 0, 1);
  endtask

  task automatic t_random();
    for (int k = 0; k < 60; k++)
      run_pair($urandom % 256, $urandom % 256, $urandom % 3, $urandom % 4, k[0]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_directed();
    t_zero();
    t_noise();
    t_random();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule